// File: doc/BRIEF.md
# Power Management Register Pair

This block holds the two configuration-space words through which a PCI function reports and controls its power management. The capability word is at offset 0x42. It is read-only to the host. A serial EEPROM loader can overwrite it once after reset, so a board can change the advertised feature set, for example to add event support from D3_cold. The control/status word is at offset 0x44. It holds the current power state, the event enable and the sticky event status.

The host writes 16-bit words with two byte enables and reads them back combinationally. A power management event request from the function core sets the status flag whether or not events are enabled. The event output is raised only while both the status flag and the enable are set. The current power state goes to the rest of the chip on its own port.

Top module: `pm_regs`

## Requirements
- R1: After reset the capability word reads 0x7E22, the control/status word reads 0x0000 and `pmeOut` is 0.
- R2: A read at offset 0x42 returns the capability word. A read at 0x44 returns the control/status word, whose bits 7..2 and 14..9 always read 0. Any other offset reads 0x0000.
- R3: Configuration writes to offset 0x42 never change the capability word.
- R4: The first `eepromLoad` strobe after reset replaces the capability word with `eepromData`. Later strobes are ignored until the next reset.
- R5: A write to 0x44 with byte enable 0 set puts data bits 1..0 into the power state (00 D0, 01 D1, 10 D2, 11 D3_hot). `powerState` shows the new value after that clock edge. With byte enable 0 clear, the state is unchanged.
- R6: A write asking for D1 while capability bit 9 is 0, or for D2 while capability bit 10 is 0, leaves the power state unchanged. D0 and D3_hot are always accepted.
- R7: A write to 0x44 with byte enable 1 set loads the event enable from data bit 8.
- R8: A cycle with `pmeRequest` high sets the status flag (bit 15 of 0x44), whatever the enable holds.
- R9: A write to 0x44 with byte enable 1 set and data bit 15 = 1 clears the status flag. Data bit 15 = 0, or byte enable 1 clear, leaves it unchanged.
- R10: When `pmeRequest` and a clearing write fall in the same cycle, the status flag stays set.
- R11: `pmeOut` is 1 exactly when both the event enable and the status flag are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 8 | Configuration byte offset of the word accessed |
| cfgByteEn | input | 2 | Byte enables for the write (bit 0 = low byte) |
| cfgWrData | input | 16 | Write data |
| cfgRdData | output | 16 | Read data for `cfgAddr` (combinational) |
| eepromLoad | input | 1 | Capability load strobe from the EEPROM loader |
| eepromData | input | 16 | Capability value to load |
| pmeRequest | input | 1 | Event request from the function core |
| pmeOut | output | 1 | Power management event output |
| powerState | output | 2 | Current power state |

## Verification
The control word is written with each byte enable alone and with both enables together. This tells lane-0 state updates apart from lane-1 enable and clear updates. The writes also carry ones in the reserved bits, to show that those bits read back as zero. The status flag is driven four ways: by an event with the enable clear and with it set, by a write-1 clear, by a write of 0, and by an event in the same cycle as a clear. Together these separate the sticky set, the clear and the priority between them. A reduced capability word loaded from EEPROM lets D1 be refused while D2 is still accepted. A second load shows it is ignored, and a load after a fresh reset shows it is accepted again.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int DATA_W      = 16;
  localparam int BE_W        = DATA_W / 8;
  localparam int PS_W        = 2;
  localparam int EN_BIT      = 8;
  localparam int STATUS_BIT  = 15;
  localparam int CAP_D1_BIT  = 9;
  localparam int CAP_D2_BIT  = 10;

  typedef enum logic [PS_W-1:0] {
    PS_D0    = 2'b00,
    PS_D1    = 2'b01,
    PS_D2    = 2'b10,
    PS_D3HOT = 2'b11
  } pwrState_t;

  typedef struct packed {
    logic      capLoad;
    logic      stateWr;
    pwrState_t stateVal;
    logic      enWr;
    logic      enVal;
    logic      statusClr;
  } pmStrobe_t;
endpackage

// File: rtl/pm_ctrl.sv
module pm_ctrl
  import pm_pkg::*;
#(
  parameter int              ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFFSET = 8'h44
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [BE_W-1:0]   cfgByteEn,
  input  logic [DATA_W-1:0] cfgWrData,
  input  logic              eepromLoad,
  input  logic [DATA_W-1:0] capWord,
  output pmStrobe_t         strobe
);
  logic loadDone;
  logic ctrlHit;
  pwrState_t reqState;
  logic stateOk;
  logic unusedDataBits;

  assign unusedDataBits = ^{cfgWrData[STATUS_BIT-1:EN_BIT+1], cfgWrData[EN_BIT-1:PS_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          loadDone <= 1'b0;
    else if (eepromLoad) loadDone <= 1'b1;
  end

  assign ctrlHit  = cfgWrEn && (cfgAddr == CTRL_OFFSET);
  assign reqState = pwrState_t'(cfgWrData[PS_W-1:0]);

  always_comb begin
    unique case (reqState)
      PS_D1:   stateOk = capWord[CAP_D1_BIT];
      PS_D2:   stateOk = capWord[CAP_D2_BIT];
      default: stateOk = 1'b1;
    endcase
  end

  always_comb begin
    strobe.capLoad   = eepromLoad && !loadDone;
    strobe.stateWr   = ctrlHit && cfgByteEn[0] && stateOk;
    strobe.stateVal  = reqState;
    strobe.enWr      = ctrlHit && cfgByteEn[1];
    strobe.enVal     = cfgWrData[EN_BIT];
    strobe.statusClr = ctrlHit && cfgByteEn[1] && cfgWrData[STATUS_BIT];
  end
endmodule

// File: rtl/pm_datapath.sv
module pm_datapath
  import pm_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] CAP_OFFSET  = 8'h42,
  parameter logic [ADDR_W-1:0] CTRL_OFFSET = 8'h44,
  parameter logic [DATA_W-1:0] CAP_RESET   = 16'h7E22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pmStrobe_t         strobe,
  input  logic [DATA_W-1:0] eepromData,
  input  logic              pmeRequest,
  input  logic [ADDR_W-1:0] cfgAddr,
  output logic [DATA_W-1:0] capWord,
  output logic [DATA_W-1:0] cfgRdData,
  output pwrState_t         curState,
  output logic              pmeEn,
  output logic              pmeStatus,
  output logic              pmeOut
);
  logic [DATA_W-1:0] ctrlWord;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              capWord <= CAP_RESET;
    else if (strobe.capLoad) capWord <= eepromData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              curState <= PS_D0;
    else if (strobe.stateWr) curState <= strobe.stateVal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           pmeEn <= 1'b0;
    else if (strobe.enWr) pmeEn <= strobe.enVal;
  end

  // Event has priority over a same-cycle clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pmeStatus <= 1'b0;
    else if (pmeRequest)       pmeStatus <= 1'b1;
    else if (strobe.statusClr) pmeStatus <= 1'b0;
  end

  always_comb begin
    ctrlWord                 = '0;
    ctrlWord[PS_W-1:0]       = curState;
    ctrlWord[EN_BIT]         = pmeEn;
    ctrlWord[STATUS_BIT]     = pmeStatus;
  end

  always_comb begin
    if (cfgAddr == CAP_OFFSET)       cfgRdData = capWord;
    else if (cfgAddr == CTRL_OFFSET) cfgRdData = ctrlWord;
    else                             cfgRdData = '0;
  end

  assign pmeOut = pmeEn & pmeStatus;
endmodule

// File: rtl/pm_regs.sv
module pm_regs
  import pm_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] CAP_OFFSET  = 8'h42,
  parameter logic [ADDR_W-1:0] CTRL_OFFSET = 8'h44,
  parameter logic [15:0]       CAP_RESET   = 16'h7E22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [1:0]        cfgByteEn,
  input  logic [15:0]       cfgWrData,
  output logic [15:0]       cfgRdData,
  input  logic              eepromLoad,
  input  logic [15:0]       eepromData,
  input  logic              pmeRequest,
  output logic              pmeOut,
  output logic [1:0]        powerState
);
  pmStrobe_t         strobe;
  logic [DATA_W-1:0] capWord;
  pwrState_t         curState;
  logic              pmeEn;
  logic              pmeStatus;

  pm_ctrl #(.ADDR_W(ADDR_W), .CTRL_OFFSET(CTRL_OFFSET)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgByteEn(cfgByteEn), .cfgWrData(cfgWrData), .eepromLoad(eepromLoad),
    .capWord(capWord), .strobe(strobe)
  );

  pm_datapath #(.ADDR_W(ADDR_W), .CAP_OFFSET(CAP_OFFSET),
                .CTRL_OFFSET(CTRL_OFFSET), .CAP_RESET(CAP_RESET)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .eepromData(eepromData),
    .pmeRequest(pmeRequest), .cfgAddr(cfgAddr), .capWord(capWord),
    .cfgRdData(cfgRdData), .curState(curState), .pmeEn(pmeEn),
    .pmeStatus(pmeStatus), .pmeOut(pmeOut)
  );

  assign powerState = curState;
endmodule

// File: rtl/pm_regs_checker.sv
module pm_regs_checker #(
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFFSET = 8'h44
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfgWrEn,
  input logic [ADDR_W-1:0] cfgAddr,
  input logic [1:0]        cfgByteEn,
  input logic [15:0]       cfgWrData,
  input logic              eepromLoad,
  input logic              pmeRequest,
  input logic              pmeOut,
  input logic [1:0]        powerState,
  input logic [15:0]       capWord,
  input logic              pmeStatus
);
  logic ctrlWrite;
  logic clearWrite;
  logic askD1;
  logic unusedChk;

  assign unusedChk  = ^cfgWrData[14:2];
  assign ctrlWrite  = cfgWrEn && (cfgAddr == CTRL_OFFSET);
  assign clearWrite = ctrlWrite && cfgByteEn[1] && cfgWrData[15];
  assign askD1      = ctrlWrite && cfgByteEn[0] && (cfgWrData[1:0] == 2'b01);

  // R3 / R4: capability changes only on a loader strobe
  p_cap_readonly_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !eepromLoad |=> $stable(capWord));

  // R5: state moves only on a configuration write
  p_state_needs_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cfgWrEn |=> $stable(powerState));

  // R6: D1 refused when not advertised
  p_no_unsupported_d1_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (askD1 && !capWord[9]) |=> $stable(powerState));

  // R8: event always sets the status flag
  p_event_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pmeRequest |=> pmeStatus);

  // R9: status flag is sticky without a clearing write
  p_status_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pmeStatus && !clearWrite) |=> pmeStatus);

  // R11: event output rises only after an event or a write
  p_pme_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pmeOut) |-> ($past(pmeRequest) || $past(cfgWrEn)));
endmodule

bind pm_regs pm_regs_checker #(.ADDR_W(ADDR_W), .CTRL_OFFSET(CTRL_OFFSET)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
  .cfgByteEn(cfgByteEn), .cfgWrData(cfgWrData), .eepromLoad(eepromLoad),
  .pmeRequest(pmeRequest), .pmeOut(pmeOut), .powerState(powerState),
  .capWord(capWord), .pmeStatus(pmeStatus)
);

// File: tb/pm_regs_bench.sv
`timescale 1ns/1ps
module pm_regs_bench;
  // vector: {op[3:0], addr[7:0], be[3:0], data[15:0], exp[15:0]}
  // op 1 = write, 2 = read and compare, 3 = event pulse, 4 = compare pmeOut with exp[0]
  localparam int NVEC = 26;
  localparam logic [47:0] VEC [NVEC] = '{
    {4'd2, 8'h42, 4'h0, 16'h0000, 16'h7E22},  // R1
    {4'd2, 8'h44, 4'h0, 16'h0000, 16'h0000},  // R1
    {4'd2, 8'h40, 4'h0, 16'h0000, 16'h0000},  // R2
    {4'd1, 8'h42, 4'h3, 16'h0000, 16'h0000},
    {4'd2, 8'h42, 4'h0, 16'h0000, 16'h7E22},  // R3
    {4'd1, 8'h44, 4'h1, 16'h0002, 16'h0000},
    {4'd2, 8'h44, 4'h0, 16'h0000, 16'h0002},  // R5
    {4'd1, 8'h44, 4'h2, 16'h0003, 16'h0000},
    {4'd2, 8'h44, 4'h0, 16'h0000, 16'h0002},  // R5 lane 0 off
    {4'd1, 8'h44, 4'h3, 16'h7EFF, 16'h0000},
    {4'd2, 8'h44, 4'h0, 16'h0000, 16'h0003},  // R2 reserved zero
    {4'd3, 8'h44, 4'h0, 16'h0000, 16'h0000},
    {4'd2, 8'h44, 4'h0, 16'h0000, 16'h8003},  // R8
    {4'd4, 8'h44, 4'h0, 16'h0000, 16'h0000},  // R11
    {4'd1, 8'h44, 4'h2, 16'h0100, 16'h0000},
    {4'd2, 8'h44, 4'h0, 16'h0000, 16'h8103},  // R7, R9 write 0
    {4'd4, 8'h44, 4'h0, 16'h0000, 16'h0001},  // R11
    {4'd1, 8'h44, 4'h1, 16'h8003, 16'h0000},
    {4'd2, 8'h44, 4'h0, 16'h0000, 16'h8103},  // R9 lane 1 off
    {4'd1, 8'h44, 4'h2, 16'h8100, 16'h0000},
    {4'd2, 8'h44, 4'h0, 16'h0000, 16'h0103},  // R9 clear
    {4'd4, 8'h44, 4'h0, 16'h0000, 16'h0000},  // R11
    {4'd2, 8'h46, 4'h0, 16'h0000, 16'h0000},  // R2
    {4'd1, 8'h44, 4'h3, 16'h0000, 16'h0000},
    {4'd2, 8'h44, 4'h0, 16'h0000, 16'h0000},  // R5 back to D0
    {4'd4, 8'h44, 4'h0, 16'h0000, 16'h0000}   // R11
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [7:0]  cfgAddr = '0;
  logic [1:0]  cfgByteEn = '0;
  logic [15:0] cfgWrData = '0;
  logic [15:0] cfgRdData;
  logic        eepromLoad = 1'b0;
  logic [15:0] eepromData = '0;
  logic        pmeRequest = 1'b0;
  logic        pmeOut;
  logic [1:0]  powerState;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  pm_regs u_pm_regs (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgByteEn(cfgByteEn), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .eepromLoad(eepromLoad), .eepromData(eepromData), .pmeRequest(pmeRequest),
    .pmeOut(pmeOut), .powerState(powerState)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [7:0] a, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgByteEn = be; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0; cfgByteEn = '0; cfgWrData = '0;
  endtask

  task automatic readCheck(input string req, input logic [7:0] a, input logic [15:0] exp);
    @(negedge clk);
    cfgAddr = a;
    #1 check(req, cfgRdData, exp);
  endtask

  task automatic pulseEvent();
    @(negedge clk); pmeRequest = 1'b1;
    @(negedge clk); pmeRequest = 1'b0;
  endtask

  task automatic eepromPulse(input logic [15:0] d);
    @(negedge clk); eepromLoad = 1'b1; eepromData = d;
    @(negedge clk); eepromLoad = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 pmeOut", {15'd0, pmeOut}, 16'h0000);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      case (VEC[i][47:44])
        4'd1: cfgWrite(VEC[i][43:36], VEC[i][33:32], VEC[i][31:16]);
        4'd2: readCheck($sformatf("vector %0d (R1/R2/R3/R5/R7/R8/R9)", i), VEC[i][43:36], VEC[i][15:0]);
        4'd3: pulseEvent();
        default: begin
          @(negedge clk);
          check($sformatf("vector %0d R11", i), {15'd0, pmeOut}, VEC[i][15:0]);
        end
      endcase
    end

    // R10: event and clear in the same cycle
    cfgWrite(8'h44, 2'b10, 16'h0100);
    pulseEvent();
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = 8'h44; cfgByteEn = 2'b10; cfgWrData = 16'h8100;
    pmeRequest = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0; cfgByteEn = '0; pmeRequest = 1'b0;
    readCheck("R10 status kept", 8'h44, 16'h8100);
    check("R10 pmeOut", {15'd0, pmeOut}, 16'h0001);

    // R4 / R6: reduced capability without D1
    doReset();
    readCheck("R1 after reset", 8'h44, 16'h0000);
    check("R1 pmeOut after reset", {15'd0, pmeOut}, 16'h0000);
    eepromPulse(16'h7C22);
    readCheck("R4 first load", 8'h42, 16'h7C22);
    cfgWrite(8'h44, 2'b01, 16'h0001);
    check("R6 D1 refused", {14'd0, powerState}, 16'h0000);
    cfgWrite(8'h44, 2'b01, 16'h0002);
    check("R5 D2 accepted", {14'd0, powerState}, 16'h0002);
    cfgWrite(8'h44, 2'b01, 16'h0003);
    check("R6 D3hot accepted", {14'd0, powerState}, 16'h0003);
    eepromPulse(16'hFE22);
    readCheck("R4 second load ignored", 8'h42, 16'h7C22);

    // R6: D2 refused when capability bit 10 is clear
    doReset();
    eepromPulse(16'h7A22);
    cfgWrite(8'h44, 2'b01, 16'h0002);
    check("R6 D2 refused", {14'd0, powerState}, 16'h0000);
    cfgWrite(8'h44, 2'b01, 16'h0001);
    check("R6 D1 accepted", {14'd0, powerState}, 16'h0001);

    // R4: load accepted again after reset
    doReset();
    readCheck("R1 capability after reset", 8'h42, 16'h7E22);
    eepromPulse(16'hFE22);
    readCheck("R4 load after reset", 8'h42, 16'hFE22);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule